// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside one processor core and performs the hardware part of taking an interrupt. A one-cycle `start_i` pulse launches a fixed sequence. The block first requests an acknowledge from the interrupt controller and waits for the returned interrupt number. The number 1023 means there is no interrupt to take, and the sequence then ends without touching any register. For any other number, the block banks the current state word and program counter into the saved-state and link registers. It then moves the exception-level field of the state word to level 1. If the vector base is nonzero, it redirects the program counter to the IRQ vector.

The states are IDLE, ACK, SAVE, CHECK_VBAR, JUMP and DONE. The transitions are:
- IDLE to ACK on `start_i`.
- ACK stays in ACK while `ack_valid_i` is low.
- ACK to DONE when `ack_valid_i` is high and the ID is 1023.
- ACK to SAVE when `ack_valid_i` is high and the ID is any other value.
- SAVE to CHECK_VBAR unconditionally.
- CHECK_VBAR to DONE when the vector base is zero.
- CHECK_VBAR to JUMP when the vector base is nonzero.
- JUMP to DONE unconditionally.
- DONE to IDLE unconditionally.

Each write to a core register appears as a one-cycle write strobe with its data. The outcome appears on `done_o` together with `delivered_o` and `irq_id_o`.

Top module: `irq_entry_seq`

## Requirements
- R1: `start_i` is accepted only in IDLE. A start held high or pulsed while a sequence runs causes no second sequence and no extra register writes.
- R2: In ACK, `ack_req_o` stays high until `ack_valid_i` is seen. If `ack_id_i` is 1023, the next state is DONE, no write strobe fires and `delivered_o` is 0.
- R3: In SAVE, for one cycle, `spsr_we_o` and `elr_we_o` fire together. They carry `pstate_i` and `pc_i` as sampled in that cycle.
- R4: In CHECK_VBAR, `pstate_we_o` fires once. It carries the state word saved in SAVE, with bits [3:2] replaced by 2'b01 and all other bits kept.
- R5: With a nonzero vector base, JUMP fires `pc_we_o` once. It carries the vector base sampled in CHECK_VBAR plus 0x480.
- R6: With a zero vector base, the sequence goes from CHECK_VBAR straight to DONE. `pc_we_o` never fires and `delivered_o` is 0.
- R7: DONE lasts exactly one cycle. `done_o` is high in that cycle. `delivered_o` is 1 only if the PC was redirected, and `irq_id_o` then holds the acknowledged ID.
- R8: Let the start-sampling edge be the reference and W the number of wait cycles in ACK. `done_o` is visible W+5 cycles later for a delivery, W+4 for a zero vector base, and W+2 for a spurious ID.
- R9: After reset, the block is in IDLE with `ack_req_o`, `done_o` and every write strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to take an interrupt |
| ack_req_o | output | 1 | Acknowledge request to the controller |
| ack_valid_i | input | 1 | Acknowledge value is valid |
| ack_id_i | input | IDW | Acknowledged interrupt number (1023 = none) |
| pstate_i | input | XLEN | Current processor state word |
| pc_i | input | XLEN | Current program counter |
| vbar_i | input | XLEN | Vector base register value |
| spsr_we_o | output | 1 | Saved-state register write strobe |
| spsr_o | output | XLEN | Saved-state register write data |
| elr_we_o | output | 1 | Link register write strobe |
| elr_o | output | XLEN | Link register write data |
| pstate_we_o | output | 1 | State word write strobe |
| pstate_o | output | XLEN | New state word |
| pc_we_o | output | 1 | Program counter write strobe |
| pc_o | output | XLEN | New program counter |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| delivered_o | output | 1 | Interrupt was taken (valid with `done_o`) |
| irq_id_o | output | IDW | Acknowledged ID (valid with `done_o`) |

## Verification
Every result is tied to a fixed cycle after the edge that samples `start_i`:
- The link and saved-state writes come W+2 cycles later.
- The state word write comes W+3 cycles later.
- The PC write comes W+4 cycles later.
- `done_o` comes W+5, W+4 or W+2 cycles later, depending on the outcome.

The bench stamps each observed strobe with a cycle counter at the falling edge. It then compares both the cycle of `done_o` and the number of times each strobe fired against these figures. The controller model delays its acknowledge by a chosen W, so the latency checks cover waits other than zero.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_ACK        = 3'd1,
        ST_SAVE       = 3'd2,
        ST_CHECK_VBAR = 3'd3,
        ST_JUMP       = 3'd4,
        ST_DONE       = 3'd5
    } entry_state_e;
endpackage

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
#(
    parameter int IDW         = 10,
    parameter int SPURIOUS_ID = 1023
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           ack_valid_i,
    input  logic [IDW-1:0] ack_id_i,
    input  logic           vbar_zero_i,
    output entry_state_e   state_o
);
    localparam logic [IDW-1:0] SPUR = IDW'(SPURIOUS_ID);

    entry_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start_i) state_d = ST_ACK;
            ST_ACK:        if (ack_valid_i) state_d = (ack_id_i == SPUR) ? ST_DONE : ST_SAVE;
            ST_SAVE:       state_d = ST_CHECK_VBAR;
            ST_CHECK_VBAR: state_d = vbar_zero_i ? ST_DONE : ST_JUMP;
            ST_JUMP:       state_d = ST_DONE;
            ST_DONE:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;

    // R7: DONE is always followed by IDLE
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));
    // R1: start outside IDLE never returns the machine to ACK directly
    assert_start_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAVE && start_i) |=> (state_q == ST_CHECK_VBAR));
endmodule

// File: rtl/irq_entry_datapath.sv
module irq_entry_datapath
    import irq_entry_pkg::*;
#(
    parameter int          XLEN       = 64,
    parameter int          IDW        = 10,
    parameter int          EL_LSB     = 2,
    parameter int unsigned VEC_OFFSET = 32'h480
) (
    input  logic            clk,
    input  logic            rst_n,
    input  entry_state_e    state_i,
    input  logic            ack_valid_i,
    input  logic [IDW-1:0]  ack_id_i,
    input  logic [XLEN-1:0] pstate_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] vbar_i,
    output logic            vbar_zero_o,
    output logic            ack_req_o,
    output logic            spsr_we_o,
    output logic [XLEN-1:0] spsr_o,
    output logic            elr_we_o,
    output logic [XLEN-1:0] elr_o,
    output logic            pstate_we_o,
    output logic [XLEN-1:0] pstate_o,
    output logic            pc_we_o,
    output logic [XLEN-1:0] pc_o,
    output logic            done_o,
    output logic            delivered_o,
    output logic [IDW-1:0]  irq_id_o
);
    localparam logic [XLEN-1:0] EL_MASK = XLEN'(3) << EL_LSB;
    localparam logic [XLEN-1:0] EL_ONE  = XLEN'(1) << EL_LSB;
    localparam logic [XLEN-1:0] VOFF    = XLEN'(VEC_OFFSET);

    logic [IDW-1:0]  id_q;
    logic [XLEN-1:0] saved_q;
    logic [XLEN-1:0] vbar_q;
    logic            deliv_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q    <= '0;
            saved_q <= '0;
            vbar_q  <= '0;
            deliv_q <= 1'b0;
        end else begin
            unique case (state_i)
                ST_IDLE:       deliv_q <= 1'b0;
                ST_ACK:        if (ack_valid_i) id_q <= ack_id_i;
                ST_SAVE:       saved_q <= pstate_i;
                ST_CHECK_VBAR: vbar_q <= vbar_i;
                ST_JUMP:       deliv_q <= 1'b1;
                ST_DONE:       ;
                default:       ;
            endcase
        end
    end

    always_comb begin
        ack_req_o   = (state_i == ST_ACK);
        spsr_we_o   = (state_i == ST_SAVE);
        elr_we_o    = (state_i == ST_SAVE);
        pstate_we_o = (state_i == ST_CHECK_VBAR);
        pc_we_o     = (state_i == ST_JUMP);
        done_o      = (state_i == ST_DONE);
        spsr_o      = pstate_i;
        elr_o       = pc_i;
        pstate_o    = (saved_q & ~EL_MASK) | EL_ONE;
        pc_o        = vbar_q + VOFF;
        delivered_o = deliv_q;
        irq_id_o    = id_q;
        vbar_zero_o = (vbar_i == '0);
    end

    // R4: level change only after the state word was banked
    assert_el_after_save_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pstate_we_o |-> $past(spsr_we_o));
    // R5: redirect target tracks the base seen one cycle earlier
    assert_jump_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we_o |-> (pc_o == $past(vbar_i) + VOFF));
    // R6: a delivery report implies the PC was written just before
    assert_deliver_needs_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && delivered_o) |-> $past(pc_we_o));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int          XLEN        = 64,
    parameter int          IDW         = 10,
    parameter int          SPURIOUS_ID = 1023,
    parameter int          EL_LSB      = 2,
    parameter int unsigned VEC_OFFSET  = 32'h480
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    output logic            ack_req_o,
    input  logic            ack_valid_i,
    input  logic [IDW-1:0]  ack_id_i,
    input  logic [XLEN-1:0] pstate_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] vbar_i,
    output logic            spsr_we_o,
    output logic [XLEN-1:0] spsr_o,
    output logic            elr_we_o,
    output logic [XLEN-1:0] elr_o,
    output logic            pstate_we_o,
    output logic [XLEN-1:0] pstate_o,
    output logic            pc_we_o,
    output logic [XLEN-1:0] pc_o,
    output logic            done_o,
    output logic            delivered_o,
    output logic [IDW-1:0]  irq_id_o
);
    entry_state_e state;
    logic         vbar_zero;

    irq_entry_fsm #(.IDW(IDW), .SPURIOUS_ID(SPURIOUS_ID)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_valid_i(ack_valid_i),
        .ack_id_i(ack_id_i), .vbar_zero_i(vbar_zero), .state_o(state)
    );

    irq_entry_datapath #(.XLEN(XLEN), .IDW(IDW), .EL_LSB(EL_LSB), .VEC_OFFSET(VEC_OFFSET)) u_dp (
        .clk(clk), .rst_n(rst_n), .state_i(state), .ack_valid_i(ack_valid_i),
        .ack_id_i(ack_id_i), .pstate_i(pstate_i), .pc_i(pc_i), .vbar_i(vbar_i),
        .vbar_zero_o(vbar_zero), .ack_req_o(ack_req_o),
        .spsr_we_o(spsr_we_o), .spsr_o(spsr_o), .elr_we_o(elr_we_o), .elr_o(elr_o),
        .pstate_we_o(pstate_we_o), .pstate_o(pstate_o), .pc_we_o(pc_we_o), .pc_o(pc_o),
        .done_o(done_o), .delivered_o(delivered_o), .irq_id_o(irq_id_o)
    );

    // R2: spurious acknowledge ends the sequence next cycle, nothing banked
    assert_spurious_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req_o && ack_valid_i && ack_id_i == IDW'(SPURIOUS_ID))
        |=> (done_o && !spsr_we_o && !delivered_o));
    // R7: completion pulse is one cycle wide
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R3: both banked registers written in the same cycle
    assert_save_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        spsr_we_o |-> (elr_we_o && !pstate_we_o && !pc_we_o));
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb_top;
    localparam int XLEN = 64;
    localparam int IDW  = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic            ack_req_o;
    logic            ack_valid_i = 1'b0;
    logic [IDW-1:0]  ack_id_i = '0;
    logic [XLEN-1:0] pstate_i = '0, pc_i = '0, vbar_i = '0;
    logic            spsr_we_o, elr_we_o, pstate_we_o, pc_we_o, done_o, delivered_o;
    logic [XLEN-1:0] spsr_o, elr_o, pstate_o, pc_o;
    logic [IDW-1:0]  irq_id_o;

    always #5 clk = ~clk;

    irq_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_req_o(ack_req_o),
        .ack_valid_i(ack_valid_i), .ack_id_i(ack_id_i), .pstate_i(pstate_i),
        .pc_i(pc_i), .vbar_i(vbar_i), .spsr_we_o(spsr_we_o), .spsr_o(spsr_o),
        .elr_we_o(elr_we_o), .elr_o(elr_o), .pstate_we_o(pstate_we_o),
        .pstate_o(pstate_o), .pc_we_o(pc_we_o), .pc_o(pc_o), .done_o(done_o),
        .delivered_o(delivered_o), .irq_id_o(irq_id_o)
    );

    int n_tests = 0, n_fail = 0;
    int cyc = 0, ack_wait = 0, wait_cnt = 0;
    int n_spsr, n_elr, n_pst, n_pc, n_done, done_cyc;
    logic [XLEN-1:0] spsr_v, elr_v, pst_v, pc_v;
    logic del_v;
    logic [IDW-1:0] id_v;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // monitor and acknowledge responder, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (spsr_we_o)   begin n_spsr++; spsr_v = spsr_o; end
        if (elr_we_o)    begin n_elr++;  elr_v  = elr_o;  end
        if (pstate_we_o) begin n_pst++;  pst_v  = pstate_o; end
        if (pc_we_o)     begin n_pc++;   pc_v   = pc_o;   end
        if (done_o)      begin n_done++; done_cyc = cyc; del_v = delivered_o; id_v = irq_id_o; end
        if (ack_req_o) begin
            if (wait_cnt >= ack_wait) ack_valid_i = 1'b1;
            else wait_cnt++;
        end else begin
            ack_valid_i = 1'b0;
            wait_cnt = 0;
        end
    end

    task automatic run_seq(input string tag, input logic [IDW-1:0] id,
                           input logic [XLEN-1:0] pst, input logic [XLEN-1:0] pc,
                           input logic [XLEN-1:0] vb, input int w, input bit hold);
        int start_cyc, exp_lat, exp_spsr, exp_pst, exp_pc;
        bit exp_del;
        @(negedge clk); #1;
        n_spsr = 0; n_elr = 0; n_pst = 0; n_pc = 0; n_done = 0; done_cyc = 0;
        ack_wait = w; ack_id_i = id; pstate_i = pst; pc_i = pc; vbar_i = vb;
        start_i = 1'b1; start_cyc = cyc;
        @(negedge clk); #1;
        if (!hold) start_i = 1'b0;
        for (int k = 0; k < 40 && n_done == 0; k++) begin
            @(negedge clk); #1;
        end
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        exp_del  = (id != 10'd1023) && (vb != '0);
        exp_lat  = (id == 10'd1023) ? w + 2 : (vb == '0) ? w + 4 : w + 5;
        exp_spsr = (id == 10'd1023) ? 0 : 1;
        exp_pst  = exp_spsr;
        exp_pc   = exp_del ? 1 : 0;
        chk(n_done == 1, "R7", {tag, " done count"}, n_done, 1);
        chk(done_cyc - start_cyc == exp_lat, "R8", {tag, " done latency"}, done_cyc - start_cyc, exp_lat);
        chk(del_v == exp_del, "R7", {tag, " delivered"}, del_v, exp_del);
        chk(n_spsr == exp_spsr && n_elr == exp_spsr, "R3", {tag, " save writes"}, n_spsr, exp_spsr);
        chk(n_pst == exp_pst, "R4", {tag, " state word writes"}, n_pst, exp_pst);
        chk(n_pc == exp_pc, exp_del ? "R5" : "R6", {tag, " pc writes"}, n_pc, exp_pc);
        if (exp_del) begin
            chk(id_v == id, "R7", {tag, " irq id"}, id_v, id);
            chk(pc_v == vb + 64'h480, "R5", {tag, " vector target"}, pc_v, vb + 64'h480);
        end
        if (exp_spsr == 1) begin
            chk(spsr_v == pst, "R3", {tag, " saved state"}, spsr_v, pst);
            chk(elr_v == pc, "R3", {tag, " link value"}, elr_v, pc);
            chk(pst_v == ((pst & ~64'hC) | 64'h4), "R4", {tag, " new state word"},
                pst_v, (pst & ~64'hC) | 64'h4);
        end
    endtask

    task automatic test_reset();
        @(negedge clk); #1;
        chk(!ack_req_o && !done_o && !spsr_we_o && !elr_we_o && !pstate_we_o && !pc_we_o,
            "R9", "outputs idle after reset",
            {ack_req_o, done_o, spsr_we_o, elr_we_o, pstate_we_o, pc_we_o}, 0);
    endtask

    task automatic test_busy_start();
        // R1: start held high across the whole sequence gives one run only
        run_seq("R1 held start", 10'd77, 64'h8C, 64'h1000, 64'h4000, 1, 1'b1);
        @(negedge clk); #1;
        chk(!ack_req_o, "R1", "no restart after held start", ack_req_o, 0);
    endtask

    task automatic test_ack_wait();
        // R2: acknowledge request stays up while the controller stalls
        int seen = 0;
        @(negedge clk); #1;
        ack_wait = 4; ack_id_i = 10'd5; vbar_i = 64'h100;
        start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
        for (int k = 0; k < 5; k++) begin
            if (ack_req_o) seen++;
            @(negedge clk); #1;
        end
        chk(seen == 5, "R2", "ack request held while waiting", seen, 5);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_seq("basic delivery", 10'd42, 64'h3C5, 64'h0040_2000, 64'h8_0000, 0, 1'b0);
        run_seq("field 11 to 01", 10'd300, 64'h2CD, 64'hDEAD_0000, 64'hFFFF_0000, 0, 1'b0);
        run_seq("field from zero", 10'd1022, 64'h0, 64'h10, 64'h800, 2, 1'b0);
        run_seq("R2 spurious", 10'd1023, 64'h5, 64'h20, 64'h8_0000, 0, 1'b0);
        run_seq("R2 spurious waited", 10'd1023, 64'h5, 64'h20, 64'h8_0000, 3, 1'b0);
        run_seq("R6 zero base", 10'd42, 64'hC, 64'h30, 64'h0, 0, 1'b0);
        run_seq("R6 zero base waited", 10'd0, 64'hF, 64'h40, 64'h0, 2, 1'b0);
        test_busy_start();
        test_ack_wait();
        run_seq("back to back", 10'd1, 64'h4, 64'h50, 64'h1_0000, 0, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule